// File: doc/BRIEF.md
# Pipelined RGB to YCbCr Colour Converter

This block sits between the pixel fetch path and the parallel display output. Each cycle it may accept one 24-bit RGB pixel, qualified by a valid flag and marked with a line-end flag. It has three output modes. It can pass the pixel through unchanged on 24 bits. It can repack the pixel to 16-bit RGB565. It can convert the pixel to YCbCr with a programmable signed 3x3 matrix and three offsets, and then emit a 16-bit UYVY stream in which chroma is carried on alternate pixels.

The matrix, the offsets and the mode sit behind a small write-only register port. A write is taken only while no pixel is being presented. Every value a pixel needs is captured together with that pixel in the first pipeline stage. A pixel therefore never mixes old and new settings, even while earlier pixels are still in flight. After reset the matrix holds full-range BT.601 values, so conversion works without any programming.

Top module: `pix_csc`

## Requirements
- R1: While reset is asserted, and until the first pixel comes out after reset, `out_valid` and `out_last` are 0 and `out_data` is 0. The mode after reset is 24-bit pass-through.
- R2: In 24-bit pass-through mode (mode register value bit1=0, bit0=0), `out_data` equals `in_rgb`, laid out as {R[23:16], G[15:8], B[7:0]}.
- R3: In RGB565 mode (bit1=0, bit0=1), `out_data` is {8'h00, R[7:3], G[7:2], B[7:3]}.
- R4: In conversion mode (bit1=1), each channel k (Y, Cb, Cr) is computed as ((Ck0·R + Ck1·G + Ck2·B + 128) >>> 8) + Dk. The shift is arithmetic. The coefficients C are 11-bit two's complement in units of 1/256, and the offsets D are 11-bit two's complement.
- R5: Each converted channel is clamped to the range 0 to 255 before it is output.
- R6: In conversion mode, `out_data[23:16]` is 0. An even pixel of a line outputs {Cb, Y} on [15:0] and an odd pixel outputs {Cr, Y}.
- R7: The even/odd pair phase returns to even after every pixel flagged with `in_last`. It also starts even after reset.
- R8: Each pixel appears on the outputs three clock edges after it is sampled. `out_valid` and `out_last` stay aligned with their data. No output appears without an input.
- R9: A write on `cfg_we` in a cycle where `in_valid` is 1 is dropped. It changes no coefficient, offset or mode.
- R10: The register addresses are as follows. Addresses 0 to 8 hold the matrix in row order, with rows Y, Cb, Cr and columns R, G, B, so that address = 3·row + column. Addresses 9, 10 and 11 hold the offsets for Y, Cb and Cr. Address 12 holds the mode in `cfg_wdata[1:0]`. Pixels sampled after a write use the new value.
- R11: After reset the matrix holds 0x04C, 0x096, 0x01D / 0x7D5, 0x7AC, 0x080 / 0x080, 0x795, 0x7EC, and the offsets hold 0x000, 0x080, 0x080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 11 | Register write data |
| in_valid | input | 1 | Input pixel valid |
| in_last | input | 1 | Input pixel ends a line |
| in_rgb | input | 24 | Input pixel {R, G, B} |
| out_valid | output | 1 | Output word valid |
| out_last | output | 1 | Output word ends a line |
| out_data | output | 24 | RGB888, RGB565 or UYVY word |

## Verification
The bench aims at the edges of the arithmetic. Saturated white, black and pure red drive the Y and chroma results past 0 and past 255. A rounding error or a missing clamp would then show up as an off-by-one value or as a wrapped value. Lines of odd length test whether the chroma phase restarts after a line end; if it did not, Cr and Cb would swap on the next line. Writes issued while a pixel is being presented test the write guard; a design without the guard would change the following pixels. Every output word is checked for the exact cycle in which it arrives, so a stage that is missing or added shows up as a timing miscompare.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int COMP_W_D = 8;
  localparam int COEF_W_D = 11;
  localparam int FRAC_D   = 8;
  localparam int NCOEF    = 9;
  localparam int NCH      = 3;

  typedef enum logic [1:0] {
    CSC_RGB888 = 2'd0,
    CSC_RGB565 = 2'd1,
    CSC_YUV    = 2'd2
  } csc_mode_e;

  // full-range BT.601 defaults, rows Y/Cb/Cr, columns R/G/B
  function automatic int dflt_coef(input int idx);
    case (idx)
      0: return 76;   1: return 150;  2: return 29;
      3: return -43;  4: return -84;  5: return 128;
      6: return 128;  7: return -107; 8: return -20;
      default: return 0;
    endcase
  endfunction

  function automatic int dflt_off(input int idx);
    return (idx == 0) ? 0 : 128;
  endfunction
endpackage

// File: rtl/csc_cfg.sv
module csc_cfg
  import csc_pkg::*;
#(
  parameter int COEF_W = COEF_W_D,
  parameter int ADDR_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [ADDR_W-1:0]            cfg_addr,
  input  logic [COEF_W-1:0]            cfg_wdata,
  input  logic                         busy,
  output logic [NCOEF-1:0][COEF_W-1:0] coef_o,
  output logic [NCH-1:0][COEF_W-1:0]   off_o,
  output csc_mode_e                    mode_o
);
  localparam int MODE_ADDR = NCOEF + NCH;

  logic [NCOEF-1:0][COEF_W-1:0] coef_q, coef_d;
  logic [NCH-1:0][COEF_W-1:0]   off_q, off_d;
  csc_mode_e                    mode_q, mode_d;
  logic                         wr_ok;

  assign wr_ok = cfg_we & ~busy;

  always_comb begin
    coef_d = coef_q;
    off_d  = off_q;
    mode_d = mode_q;
    for (int i = 0; i < NCOEF; i++)
      if (wr_ok && cfg_addr == ADDR_W'(i)) coef_d[i] = cfg_wdata;
    for (int i = 0; i < NCH; i++)
      if (wr_ok && cfg_addr == ADDR_W'(NCOEF + i)) off_d[i] = cfg_wdata;
    if (wr_ok && cfg_addr == ADDR_W'(MODE_ADDR))
      mode_d = cfg_wdata[1] ? CSC_YUV : (cfg_wdata[0] ? CSC_RGB565 : CSC_RGB888);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCOEF; i++) coef_q[i] <= COEF_W'(dflt_coef(i));
      for (int i = 0; i < NCH; i++)   off_q[i]  <= COEF_W'(dflt_off(i));
      mode_q <= CSC_RGB888;
    end else begin
      coef_q <= coef_d;
      off_q  <= off_d;
      mode_q <= mode_d;
    end
  end

  assign coef_o = coef_q;
  assign off_o  = off_q;
  assign mode_o = mode_q;

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && busy) |=> ($stable(coef_q) && $stable(off_q) && $stable(mode_q)));
endmodule

// File: rtl/csc_mult.sv
module csc_mult
  import csc_pkg::*;
#(
  parameter int COMP_W = COMP_W_D,
  parameter int COEF_W = COEF_W_D,
  localparam int PROD_W = COMP_W + 1 + COEF_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic                         in_last,
  input  logic [3*COMP_W-1:0]          in_rgb,
  input  logic [NCOEF-1:0][COEF_W-1:0] coef,
  input  logic [NCH-1:0][COEF_W-1:0]   off,
  input  csc_mode_e                    mode,
  output logic                         s1_valid,
  output logic                         s1_last,
  output logic [3*COMP_W-1:0]          s1_rgb,
  output logic [NCOEF-1:0][PROD_W-1:0] s1_prod,
  output logic [NCH-1:0][COEF_W-1:0]   s1_off,
  output csc_mode_e                    s1_mode
);
  logic [NCOEF-1:0][PROD_W-1:0] prod_d;

  for (genvar gi = 0; gi < NCOEF; gi++) begin : g_mul
    localparam int COL = gi % NCH;
    logic [COMP_W-1:0]        comp;
    logic signed [PROD_W-1:0] a_ext, b_ext, p;
    assign comp  = in_rgb[(NCH-1-COL)*COMP_W +: COMP_W];
    assign a_ext = {{(PROD_W-COMP_W){1'b0}}, comp};
    assign b_ext = {{(PROD_W-COEF_W){coef[gi][COEF_W-1]}}, coef[gi]};
    assign p     = a_ext * b_ext;
    assign prod_d[gi] = p;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_last  <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_last  <= in_valid & in_last;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_rgb  <= in_rgb;
      s1_prod <= prod_d;
      s1_off  <= off;
      s1_mode <= mode;
    end
  end
endmodule

// File: rtl/csc_sum.sv
module csc_sum
  import csc_pkg::*;
#(
  parameter int COMP_W = COMP_W_D,
  parameter int COEF_W = COEF_W_D,
  parameter int FRAC   = FRAC_D,
  localparam int PROD_W = COMP_W + 1 + COEF_W,
  localparam int ACC_W  = PROD_W + 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         s1_valid,
  input  logic                         s1_last,
  input  logic [3*COMP_W-1:0]          s1_rgb,
  input  logic [NCOEF-1:0][PROD_W-1:0] s1_prod,
  input  logic [NCH-1:0][COEF_W-1:0]   s1_off,
  input  csc_mode_e                    s1_mode,
  output logic                         s2_valid,
  output logic                         s2_last,
  output logic [3*COMP_W-1:0]          s2_rgb,
  output logic [NCH-1:0][ACC_W-1:0]    s2_acc,
  output csc_mode_e                    s2_mode
);
  localparam int RND = 1 << (FRAC - 1);

  logic [NCH-1:0][ACC_W-1:0] acc_d;

  for (genvar gr = 0; gr < NCH; gr++) begin : g_row
    logic signed [ACC_W-1:0] sum, res;
    assign sum = $signed(s1_prod[gr*NCH]) + $signed(s1_prod[gr*NCH+1])
               + $signed(s1_prod[gr*NCH+2]) + ACC_W'(RND);
    assign res = (sum >>> FRAC) + $signed(s1_off[gr]);
    assign acc_d[gr] = res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_last  <= 1'b0;
    end else begin
      s2_valid <= s1_valid;
      s2_last  <= s1_last;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      s2_rgb  <= s1_rgb;
      s2_acc  <= acc_d;
      s2_mode <= s1_mode;
    end
  end
endmodule

// File: rtl/csc_pack.sv
module csc_pack
  import csc_pkg::*;
#(
  parameter int COMP_W = COMP_W_D,
  parameter int ACC_W  = COMP_W_D + 1 + COEF_W_D + 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      s2_valid,
  input  logic                      s2_last,
  input  logic [3*COMP_W-1:0]       s2_rgb,
  input  logic [NCH-1:0][ACC_W-1:0] s2_acc,
  input  csc_mode_e                 s2_mode,
  output logic                      out_valid,
  output logic                      out_last,
  output logic [3*COMP_W-1:0]       out_data
);
  localparam int OUT_W = 3 * COMP_W;
  localparam int PAD_W = OUT_W - 2 * COMP_W;
  localparam int P565  = OUT_W - 16;

  logic [NCH-1:0][COMP_W-1:0] sat;
  logic                       odd_q, odd_d;
  logic [OUT_W-1:0]           data_d;
  logic [COMP_W-1:0]          r_c, g_c, b_c;

  for (genvar gc = 0; gc < NCH; gc++) begin : g_sat
    always_comb begin
      if (s2_acc[gc][ACC_W-1])
        sat[gc] = '0;
      else if (s2_acc[gc] > ACC_W'((1 << COMP_W) - 1))
        sat[gc] = '1;
      else
        sat[gc] = s2_acc[gc][COMP_W-1:0];
    end
  end

  assign r_c = s2_rgb[2*COMP_W +: COMP_W];
  assign g_c = s2_rgb[COMP_W +: COMP_W];
  assign b_c = s2_rgb[0 +: COMP_W];

  always_comb begin
    odd_d  = odd_q;
    data_d = out_data;
    if (s2_valid) begin
      odd_d = s2_last ? 1'b0 : ~odd_q;
      case (s2_mode)
        CSC_YUV:    data_d = {{PAD_W{1'b0}}, (odd_q ? sat[2] : sat[1]), sat[0]};
        CSC_RGB565: data_d = {{P565{1'b0}}, r_c[COMP_W-1 -: 5], g_c[COMP_W-1 -: 6], b_c[COMP_W-1 -: 5]};
        default:    data_d = s2_rgb;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_q     <= 1'b0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      odd_q     <= odd_d;
      out_valid <= s2_valid;
      out_last  <= s2_last;
      out_data  <= data_d;
    end
  end

  // R6
  yuv_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_mode == CSC_YUV) |=> (out_data[OUT_W-1 -: PAD_W] == '0));
endmodule

// File: rtl/pix_csc.sv
module pix_csc
  import csc_pkg::*;
#(
  parameter int COMP_W = COMP_W_D,
  parameter int COEF_W = COEF_W_D,
  parameter int FRAC   = FRAC_D,
  parameter int ADDR_W = 4,
  localparam int PROD_W = COMP_W + 1 + COEF_W,
  localparam int ACC_W  = PROD_W + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [COEF_W-1:0]   cfg_wdata,
  input  logic                in_valid,
  input  logic                in_last,
  input  logic [3*COMP_W-1:0] in_rgb,
  output logic                out_valid,
  output logic                out_last,
  output logic [3*COMP_W-1:0] out_data
);
  logic [1:0] rst_sync;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  logic [NCOEF-1:0][COEF_W-1:0] coef;
  logic [NCH-1:0][COEF_W-1:0]   off;
  csc_mode_e                    mode;

  csc_cfg #(.COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_s), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(in_valid),
    .coef_o(coef), .off_o(off), .mode_o(mode));

  logic                         s1_valid, s1_last;
  logic [3*COMP_W-1:0]          s1_rgb;
  logic [NCOEF-1:0][PROD_W-1:0] s1_prod;
  logic [NCH-1:0][COEF_W-1:0]   s1_off;
  csc_mode_e                    s1_mode;

  csc_mult #(.COMP_W(COMP_W), .COEF_W(COEF_W)) u_mult (
    .clk(clk), .rst_n(rst_s), .in_valid(in_valid), .in_last(in_last),
    .in_rgb(in_rgb), .coef(coef), .off(off), .mode(mode),
    .s1_valid(s1_valid), .s1_last(s1_last), .s1_rgb(s1_rgb),
    .s1_prod(s1_prod), .s1_off(s1_off), .s1_mode(s1_mode));

  logic                      s2_valid, s2_last;
  logic [3*COMP_W-1:0]       s2_rgb;
  logic [NCH-1:0][ACC_W-1:0] s2_acc;
  csc_mode_e                 s2_mode;

  csc_sum #(.COMP_W(COMP_W), .COEF_W(COEF_W), .FRAC(FRAC)) u_sum (
    .clk(clk), .rst_n(rst_s), .s1_valid(s1_valid), .s1_last(s1_last),
    .s1_rgb(s1_rgb), .s1_prod(s1_prod), .s1_off(s1_off), .s1_mode(s1_mode),
    .s2_valid(s2_valid), .s2_last(s2_last), .s2_rgb(s2_rgb),
    .s2_acc(s2_acc), .s2_mode(s2_mode));

  csc_pack #(.COMP_W(COMP_W), .ACC_W(ACC_W)) u_pack (
    .clk(clk), .rst_n(rst_s), .s2_valid(s2_valid), .s2_last(s2_last),
    .s2_rgb(s2_rgb), .s2_acc(s2_acc), .s2_mode(s2_mode),
    .out_valid(out_valid), .out_last(out_last), .out_data(out_data));

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)             age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R8
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R8
  last_lat_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (age_q == 2'd3) |-> (out_last == $past(in_valid && in_last, 3)));

  // R8
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_s)
    out_last |-> out_valid);
endmodule

// File: tb/pix_csc_tb.sv
module pix_csc_tb;
  logic        clk, rst_n, cfg_we, in_valid, in_last;
  logic [3:0]  cfg_addr;
  logic [10:0] cfg_wdata;
  logic [23:0] in_rgb, out_data;
  logic        out_valid, out_last;

  pix_csc u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_last(in_last),
    .in_rgb(in_rgb), .out_valid(out_valid), .out_last(out_last),
    .out_data(out_data));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";
  logic [23:0] exp_d [0:511];
  logic        exp_l [0:511];
  int          exp_c [0:511];
  int          wr_i = 0, rd_i = 0;

  int m_coef [0:8];
  int m_off  [0:2];
  int m_mode = 0;
  bit m_odd  = 0;
  bit done   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sx11(input logic [10:0] v);
    return v[10] ? int'(v) - 2048 : int'(v);
  endfunction

  function automatic int clamp8(input int v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  function automatic logic [23:0] ref_px(input logic [23:0] rgb, input bit odd);
    int comp [0:2];
    int ch [0:2];
    comp[0] = int'(rgb[23:16]); comp[1] = int'(rgb[15:8]); comp[2] = int'(rgb[7:0]);
    for (int r = 0; r < 3; r++) begin
      int s = 128;
      for (int c = 0; c < 3; c++) s += m_coef[r*3+c] * comp[c];
      ch[r] = clamp8((s >>> 8) + m_off[r]);
    end
    if (m_mode == 2)
      return {8'h00, (odd ? ch[2][7:0] : ch[1][7:0]), ch[0][7:0]};
    if (m_mode == 1)
      return {8'h00, rgb[23:19], rgb[15:10], rgb[7:3]};
    return rgb;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // output monitor: data, last flag and arrival cycle of every word (R8)
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (rd_i == wr_i) begin
        chk(1'b0, "R8 spurious", out_data, 24'h0);
      end else begin
        chk(out_data == exp_d[rd_i], cur_req, out_data, exp_d[rd_i]);
        chk(out_last == exp_l[rd_i], "R8 last", {23'h0, out_last}, {23'h0, exp_l[rd_i]});
        chk(cyc == exp_c[rd_i], "R8 latency", 24'(cyc), 24'(exp_c[rd_i]));
        rd_i++;
      end
    end
  end

  task automatic send(input logic [23:0] rgb, input bit last, input bit wr = 0,
                      input logic [3:0] a = 0, input logic [10:0] d = 0);
    @(negedge clk);
    in_valid = 1'b1; in_rgb = rgb; in_last = last;
    cfg_we = wr; cfg_addr = a; cfg_wdata = d;
    exp_d[wr_i] = ref_px(rgb, m_odd);
    exp_l[wr_i] = last;
    exp_c[wr_i] = cyc + 3;
    wr_i++;
    m_odd = last ? 1'b0 : ~m_odd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0; cfg_we = 1'b0;
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [10:0] d);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    if (a < 9) m_coef[a] = sx11(d);
    else if (a < 12) m_off[a-9] = sx11(d);
    else if (a == 12) m_mode = d[1] ? 2 : (d[0] ? 1 : 0);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drain();
    idle(6);
    chk(rd_i == wr_i, {cur_req, " drain"}, 24'(rd_i), 24'(wr_i));
  endtask

  task automatic t_reset();
    cur_req = "R1";
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; cfg_we = 1'b0;
    cfg_addr = '0; cfg_wdata = '0; in_rgb = '0;
    repeat (4) @(negedge clk);
    chk({out_valid, out_last} == 2'b00 && out_data == 24'h0, "R1 in reset", out_data, 24'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({out_valid, out_last} == 2'b00 && out_data == 24'h0, "R1 after reset", out_data, 24'h0);
  endtask

  task automatic t_bypass888();
    cur_req = "R2 bypass888 / R8";
    send(24'h123456, 0); send(24'hFF00A5, 0); send(24'h000000, 0); send(24'hFFFFFF, 1);
    drain();
  endtask

  task automatic t_rgb565();
    wr_reg(4'd12, 11'd1);
    cur_req = "R3 rgb565 / R10";
    send(24'hFFFFFF, 0); send(24'h8844C2, 0); send(24'h07030F, 1);
    drain();
  endtask

  task automatic t_defaults();
    wr_reg(4'd12, 11'd2);
    cur_req = "R11 defaults / R4 R5 R6";
    send(24'hFFFFFF, 0); send(24'h000000, 0); send(24'hFF0000, 0);
    send(24'h00FF00, 0); send(24'h0000FF, 0); send(24'h80A040, 1);
    drain();
  endtask

  task automatic t_phase();
    cur_req = "R7 phase restart";
    send(24'hFF0000, 0); send(24'hFF0000, 0); send(24'hFF0000, 1);
    send(24'h0000FF, 0); send(24'h0000FF, 1);
    send(24'h3060F0, 1); send(24'h3060F0, 0); send(24'h3060F0, 1);
    drain();
  endtask

  task automatic t_custom();
    cur_req = "R10 program / R4";
    wr_reg(4'd0, 11'h100); wr_reg(4'd1, 11'h000); wr_reg(4'd2, 11'h000);
    wr_reg(4'd3, 11'h000); wr_reg(4'd4, 11'h080); wr_reg(4'd5, 11'h080);
    wr_reg(4'd6, 11'h7C0); wr_reg(4'd7, 11'h000); wr_reg(4'd8, 11'h040);
    wr_reg(4'd9, 11'h005); wr_reg(4'd10, 11'h7F0); wr_reg(4'd11, 11'h020);
    send(24'h10C833, 0); send(24'hFE0102, 0); send(24'h7F7F7F, 1);
    drain();
  endtask

  task automatic t_saturate();
    cur_req = "R5 clamp";
    wr_reg(4'd9, 11'h0FF);
    send(24'hFFFFFF, 0); send(24'hC0C0C0, 1);
    drain();
    wr_reg(4'd9, 11'h700); wr_reg(4'd10, 11'h700); wr_reg(4'd11, 11'h0FF);
    send(24'h000000, 0); send(24'hFFFFFF, 0); send(24'h0000FF, 1);
    drain();
  endtask

  task automatic t_ignore();
    cur_req = "R9 write while busy";
    send(24'h405060, 0);
    send(24'h405060, 0, 1, 4'd0, 11'h3FF);
    send(24'hA0B0C0, 0, 1, 4'd9, 11'h050);
    send(24'hA0B0C0, 0, 1, 4'd12, 11'd0);
    send(24'h112233, 1);
    drain();
  endtask

  initial begin
    for (int i = 0; i < 9; i++) m_coef[i] = 0;
    m_coef[0] = 76;  m_coef[1] = 150; m_coef[2] = 29;
    m_coef[3] = -43; m_coef[4] = -84; m_coef[5] = 128;
    m_coef[6] = 128; m_coef[7] = -107; m_coef[8] = -20;
    m_off[0] = 0; m_off[1] = 128; m_off[2] = 128;
    t_reset();
    t_bypass888();
    t_rgb565();
    t_defaults();
    t_phase();
    t_custom();
    t_saturate();
    t_ignore();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule